// File: doc/BRIEF.md
# Matrix Product Checksum Verifier

This block decides whether a stored product matrix C really equals A times B, for square N×N operands, without doing the full product again. It reads the three matrices one element per cycle through a synchronous read port. From B it forms one sum per row. From C it forms one sum per row. It then multiplies A by the vector of B row sums and compares each result with the C row sum for the same row. A full multiplication costs about N³ multiply-accumulates. This check costs 3·N² reads and N² multiply-accumulates.

A start pulse begins a pass. The block runs with no further control, raises `done` for one cycle a fixed number of cycles later, and holds `err` high when any row disagrees. All sums are kept at full precision, so the comparison is exact. A fault confined to a single row of C is always caught unless it leaves that row's sum unchanged. One case of this is two equal and opposite corruptions in the same row. That case is a known blind spot of the method.

Top module: `matprod_checker`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `err` and `rdEn` are all 0.
- R2: A pass makes exactly 3·N² reads, one per cycle with `rdEn` high. It reads B (`rdMat`=1), then C (`rdMat`=2), then A (`rdMat`=0), each matrix row by row with the column running fastest. The data for a read arrives on `rdData` in the cycle after the address.
- R3: `done` is high for exactly one cycle, starting 3·N²+1 clock edges after the edge that accepted `start`.
- R4: `busy` rises at the edge that accepts `start` and is low in the cycle where `done` is high.
- R5: When C equals A·B, `err` is 0 when `done` is high.
- R6: Sums never wrap. With every A and B entry at the most negative or the most positive W-bit value and C correct, no error is reported. A and B entries are the low W bits of `rdData`, read as signed. C entries are the whole `rdData` word of 2·W+clog2(N) bits, read as signed.
- R7: Changing any single entry of C by a nonzero amount makes `err` 1 at `done`.
- R8: Corrupting entries of C in several different rows makes `err` 1 at `done`.
- R9: `err` stays set until the next accepted `start`, and it is cleared at that edge.
- R10: A `start` pulse while `busy` is high is ignored. The timing of `done` and the result are those of the running pass.
- R11: A `start` in the same cycle as `done` is accepted and begins a new pass.
- R12: Two corruptions of equal size and opposite sign in one row of C leave that row's sum unchanged and are not detected. This is the documented blind spot.
- R13: A synchronous reset during a pass aborts it. No `done` follows, and `busy` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a verification pass; accepted only when idle |
| rdEn | output | 1 | Read request for this cycle |
| rdMat | output | 2 | Matrix select: 0 = A, 1 = B, 2 = C |
| rdRow | output | clog2(N) | Row index of the read |
| rdCol | output | clog2(N) | Column index of the read |
| rdData | input | 2·W+clog2(N) | Read data, valid the cycle after the request |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| err | output | 1 | Sticky mismatch flag for the last pass |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one pass, and a `start` that opens the next. The bench provokes this by raising `start` in the very cycle where it sees `done`. It then judges that the new pass is accepted, that `err` is cleared at that edge even after a failed pass, and that the second `done` arrives exactly 3·N²+1 edges later. A second collision is a `start` raised in the middle of a pass. The bench judges this by checking that `done` keeps its original timing and appears only once.

// File: rtl/mcv_pkg.sv
package mcv_pkg;

  typedef enum logic [1:0] {
    MAT_A = 2'd0,
    MAT_B = 2'd1,
    MAT_C = 2'd2
  } matSel_t;

  typedef struct packed {
    logic    clear;
    logic    issue;
    logic    lastCol;
    logic    finish;
    matSel_t mat;
  } ctlStrobe_t;

endpackage

// File: rtl/mcv_ctrl.sv
module mcv_ctrl
  import mcv_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output ctlStrobe_t    strobe,
  output logic [IW-1:0] row,
  output logic [IW-1:0] col
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} state_t;

  state_t  state;
  matSel_t phase;
  logic    colEnd;
  logic    rowEnd;

  assign colEnd = (col == LAST);
  assign rowEnd = (row == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= MAT_B;
      row   <= '0;
      col   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            phase <= MAT_B;
            row   <= '0;
            col   <= '0;
          end
        end
        ST_RUN: begin
          if (colEnd) begin
            col <= '0;
            if (rowEnd) begin
              row <= '0;
              case (phase)
                MAT_B:   phase <= MAT_C;
                MAT_C:   phase <= MAT_A;
                default: state <= ST_TAIL;
              endcase
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            col <= col + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clear   = (state == ST_IDLE) && start;
    strobe.issue   = (state == ST_RUN);
    strobe.lastCol = colEnd;
    strobe.finish  = (state == ST_RUN) && (phase == MAT_A) && rowEnd && colEnd;
    strobe.mat     = phase;
  end

  assign busy = (state != ST_IDLE);

  // R2: addresses stay inside the matrix
  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.issue |-> (row <= LAST) && (col <= LAST));

  // R4: the drain state lasts a single cycle
  p_tail_short_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL) |=> (state == ST_IDLE));

endmodule

// File: rtl/mcv_datapath.sv
module mcv_datapath
  import mcv_pkg::*;
#(
  parameter int N   = 3,
  parameter int W   = 8,
  parameter int IW  = $clog2(N),
  parameter int CEW = 2 * W + $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  ctlStrobe_t     strobe,
  input  logic [IW-1:0]  row,
  input  logic [IW-1:0]  col,
  input  logic [CEW-1:0] rdData,
  output logic           done,
  output logic           err
);

  localparam int CL   = $clog2(N);
  localparam int BSW  = W + CL;        // B row sum
  localparam int PW   = W + BSW;       // A entry times B row sum
  localparam int ACCW = PW + CL;       // A-side row result
  localparam int CSW  = CEW + CL;      // C row sum

  // read-return pipeline stage
  logic          vQ, lastColQ, finishQ;
  matSel_t       matQ;
  logic [IW-1:0] rowQ, colQ;

  logic signed [BSW-1:0]  brSum [N];
  logic signed [CSW-1:0]  cSum  [N];
  logic signed [ACCW-1:0] acc, accNext;
  logic signed [W-1:0]    aElem;
  logic signed [PW-1:0]   prod;
  logic                   rowMismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      vQ       <= 1'b0;
      finishQ  <= 1'b0;
      lastColQ <= 1'b0;
      matQ     <= MAT_A;
      rowQ     <= '0;
      colQ     <= '0;
    end else begin
      vQ       <= strobe.issue;
      finishQ  <= strobe.finish;
      lastColQ <= strobe.lastCol;
      matQ     <= strobe.mat;
      rowQ     <= row;
      colQ     <= col;
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_rowSums
    always_ff @(posedge clk) begin
      if (rst || strobe.clear) begin
        brSum[r] <= '0;
        cSum[r]  <= '0;
      end else if (vQ && (rowQ == IW'(r))) begin
        if (matQ == MAT_B)
          brSum[r] <= brSum[r] + BSW'(signed'(rdData[W-1:0]));
        if (matQ == MAT_C)
          cSum[r] <= cSum[r] + CSW'(signed'(rdData));
      end
    end
  end

  assign aElem       = signed'(rdData[W-1:0]);
  assign prod        = PW'(aElem) * PW'(brSum[colQ]);
  assign accNext     = ((colQ == '0) ? '0 : acc) + ACCW'(prod);
  assign rowMismatch = (accNext != cSum[rowQ]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finishQ;
      if (strobe.clear) begin
        err <= 1'b0;
        acc <= '0;
      end else if (vQ && (matQ == MAT_A)) begin
        acc <= accNext;
        if (lastColQ && rowMismatch)
          err <= 1'b1;
      end
    end
  end

  // R3: done follows the last returned A element by one edge
  p_done_source_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(vQ && (matQ == MAT_A) && lastColQ));

  // R2: every returned element was requested one cycle earlier
  p_return_matches_r2: assert property (@(posedge clk) disable iff (rst)
    vQ |-> $past(strobe.issue));

endmodule

// File: rtl/matprod_checker.sv
module matprod_checker
  import mcv_pkg::*;
#(
  parameter int N = 3,
  parameter int W = 8,
  localparam int IW  = $clog2(N),
  localparam int CEW = 2 * W + $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  output logic           rdEn,
  output logic [1:0]     rdMat,
  output logic [IW-1:0]  rdRow,
  output logic [IW-1:0]  rdCol,
  input  logic [CEW-1:0] rdData,
  output logic           busy,
  output logic           done,
  output logic           err
);

  localparam int DONE_LAT = 3 * N * N + 1;

  ctlStrobe_t    strobe;
  logic [IW-1:0] row, col;

  mcv_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .strobe (strobe),
    .row    (row),
    .col    (col)
  );

  mcv_datapath #(.N(N), .W(W), .IW(IW), .CEW(CEW)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .row    (row),
    .col    (col),
    .rdData (rdData),
    .done   (done),
    .err    (err)
  );

  assign rdEn  = strobe.issue;
  assign rdMat = strobe.mat;
  assign rdRow = row;
  assign rdCol = col;

  // cycle counter used only by the latency property
  logic [31:0] sinceStart;
  always_ff @(posedge clk) begin
    if (rst)                            sinceStart <= 32'hFFFF_FFFF;
    else if (strobe.clear)              sinceStart <= '0;
    else if (sinceStart != 32'hFFFF_FFFF) sinceStart <= sinceStart + 1'b1;
  end

  // R3: fixed latency from accepted start to done
  p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (sinceStart == 32'(DONE_LAT)));

  // R3: done lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: reads happen only while busy; done falls in an idle cycle
  p_read_busy_r4: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> busy);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: err holds unless a start is accepted
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err && !(start && !busy)) |=> err);

endmodule

// File: tb/sim_matprod_checker.sv
`timescale 1ns/1ps
module sim_matprod_checker;

  localparam int N   = 3;
  localparam int W   = 8;
  localparam int IW  = $clog2(N);
  localparam int CEW = 2 * W + $clog2(N);
  localparam int LAT = 3 * N * N + 1;
  localparam int NR  = 3 * N * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rdEn, busy, done, err;
  logic [1:0] rdMat;
  logic [IW-1:0] rdRow, rdCol;
  logic [CEW-1:0] rdData = '0;

  int matA [N][N];
  int matB [N][N];
  int matC [N][N];
  int logMat [NR];
  int logRow [NR];
  int logCol [NR];
  int readIdx = 0;
  int nTests = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  matprod_checker #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .rdEn(rdEn), .rdMat(rdMat),
    .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData), .busy(busy),
    .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (rdEn) begin
      case (rdMat)
        2'd0:    rdData <= CEW'(matA[rdRow][rdCol]);
        2'd1:    rdData <= CEW'(matB[rdRow][rdCol]);
        default: rdData <= CEW'(matC[rdRow][rdCol]);
      endcase
      if (readIdx < NR) begin
        logMat[readIdx] = int'(rdMat);
        logRow[readIdx] = int'(rdRow);
        logCol[readIdx] = int'(rdCol);
      end
      readIdx++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fillProduct();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matC[i][j] = 0;
        for (int k = 0; k < N; k++) matC[i][j] += matA[i][k] * matB[k][j];
      end
  endtask

  task automatic randomOperands();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matA[i][j] = int'($urandom_range(255, 0)) - 128;
        matB[i][j] = int'($urandom_range(255, 0)) - 128;
      end
    fillProduct();
  endtask

  task automatic constOperands(input int va, input int vb);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matA[i][j] = va;
        matB[i][j] = vb;
      end
    fillProduct();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Starts a pass from the current cycle and returns at the done cycle.
  task automatic runPass(input int midStart, output int lat, output bit errOut);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy === 1'b1, "R4 busy after accept", int'(busy), 1);
    check(err === 1'b0, "R9 err cleared at accept", int'(err), 0);
    lat = 0;
    while (lat < 4 * LAT) begin
      @(posedge clk); #1;
      lat++;
      start = (lat == midStart);
      if (done) break;
    end
    start = 1'b0;
    errOut = err;
    check(busy === 1'b0, "R4 idle at done", int'(busy), 0);
  endtask

  task automatic passExpect(input bit expErr, input string req);
    int lat;
    bit e;
    runPass(-1, lat, e);
    check(lat == LAT, "R3 latency", lat, LAT);
    check(e == expErr, req, int'(e), int'(expErr));
    idle(1);
    check(done === 1'b0, "R3 single-cycle done", int'(done), 0);
    idle(2);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int lat;
    bit e;
    int cnt;
    randomOperands();
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0 && rdEn === 1'b0,
          "R1 reset outputs", int'({busy, done, err, rdEn}), 0);

    // R2 read order and count, with R5 on a correct product
    readIdx = 0;
    passExpect(1'b0, "R5 correct product");
    check(readIdx == NR, "R2 read count", readIdx, NR);
    for (int j = 0; j < NR; j++) begin
      int ph;
      int em;
      ph = j / (N * N);
      em = (ph == 0) ? 1 : (ph == 1) ? 2 : 0;
      check(logMat[j] == em, "R2 matrix order", logMat[j], em);
      check(logRow[j] == (j % (N * N)) / N, "R2 row order", logRow[j], (j % (N * N)) / N);
      check(logCol[j] == j % N, "R2 column order", logCol[j], j % N);
    end

    // R5 more random correct products
    for (int t = 0; t < 6; t++) begin
      randomOperands();
      passExpect(1'b0, "R5 correct product");
    end

    // R6 extremes
    constOperands(-128, -128); passExpect(1'b0, "R6 extreme min*min");
    constOperands(127, 127);   passExpect(1'b0, "R6 extreme max*max");
    constOperands(-128, 127);  passExpect(1'b0, "R6 extreme min*max");

    // R7 sweep of single-entry corruptions
    randomOperands();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matC[i][j] += 1 + i * N + j;
        passExpect(1'b1, "R7 single corruption");
        matC[i][j] -= 1 + i * N + j;
      end

    // R8 corruptions across rows
    matC[0][1] += 5; matC[2][2] -= 9;
    passExpect(1'b1, "R8 multi-row corruption");
    fillProduct();

    // R12 cancelling pair in one row
    matC[1][0] += 17; matC[1][2] -= 17;
    passExpect(1'b0, "R12 cancelling blind spot");
    fillProduct();

    // R9 error then clean pass back to back, R11 start during done cycle
    matC[2][0] += 3;
    runPass(-1, lat, e);
    check(e == 1'b1, "R9 error pass", int'(e), 1);
    fillProduct();
    runPass(-1, lat, e);
    check(lat == LAT, "R11 back-to-back latency", lat, LAT);
    check(e == 1'b0, "R9 err cleared by next pass", int'(e), 0);
    idle(3);

    // R10 start while busy ignored
    runPass(7, lat, e);
    check(lat == LAT, "R10 latency with mid-pass start", lat, LAT);
    cnt = 0;
    for (int i = 0; i < 2 * LAT; i++) begin
      @(posedge clk); #1;
      if (done || busy) cnt++;
    end
    check(cnt == 0, "R10 no extra pass", cnt, 0);

    // R13 reset mid-pass
    matC[0][0] += 1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    idle(LAT - 3);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    check(busy === 1'b0 && err === 1'b0 && rdEn === 1'b0,
          "R13 reset aborts", int'({busy, err, rdEn}), 0);
    cnt = 0;
    for (int i = 0; i < 2 * LAT; i++) begin
      @(posedge clk); #1;
      if (done) cnt++;
    end
    check(cnt == 0, "R13 no done after abort", cnt, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule